// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps track of a ring of receive buffer descriptors that live in a descriptor RAM shared with software. Each descriptor takes two 32-bit words in that RAM: a status word first, then a buffer address. Descriptor `i` starts at byte offset `0x400 + 8*i`. The receive descriptors sit after a programmable number of transmit descriptors, so the first receive index equals the transmit descriptor count.

When the receive path reports a finished frame, the engine reads the status word of the current descriptor. If software has marked that descriptor empty, the engine writes back the frame length and error flags, clears the empty flag and, if the descriptor requests it, latches an interrupt source. It then moves to the next descriptor. A descriptor whose wrap flag is set sends the engine back to the first receive descriptor. If the current descriptor is still owned by the engine's consumer, the frame is dropped and a busy source is latched.

A small configuration port holds three registers: the interrupt source register (write one to clear), the interrupt mask register and the transmit descriptor count. The interrupt output is the OR over the source bits that are also enabled in the mask.

Top module: `rx_desc_ring`

## Requirements
- R1: The status word of descriptor `i` is at byte address `0x400 + 8*i`. The first receive index equals the transmit count register (config select 2). A write above 128 to that register saturates to 128. After reset the register reads 0.
- R2: On an empty descriptor (status bit 15 = 1), the engine handles a frame as follows:
  - It issues the status read in the cycle after the `frameDone` edge and the status write one cycle later.
  - The written status word is length in bits 31:16, bit 15 = 0, bits 14:9 kept from the read, and the frame flags in bits 8:0.
- R3: After a write, the ring index advances by one. If the descriptor's wrap bit (bit 13) was set, the index returns to the first receive index instead.
- R4: If the current descriptor is not empty, the engine performs these steps:
  - It writes nothing.
  - It latches the busy source (bit 4).
  - It keeps the ring index unchanged.
- R5: Sources latched for a completed frame depend on the descriptor and the flags:
  - If the descriptor's interrupt-request bit (bit 14) is 0, no source is latched.
  - Otherwise, any of flag bits 7:0 latches receive error (source bit 3).
  - Otherwise, flag bit 8 (control frame) latches receive control (source bit 6).
  - Otherwise, receive frame (source bit 2) is latched.
- R6: A `frameDone` that arrives while the engine is still handling a previous frame is dropped and latches the busy source.
- R7: While `rxEnable` is low, `frameDone` has no effect on the RAM or the sources, and the ring index returns to the first receive index.
- R8: Sources latch whatever the mask (config select 1) is. Writing ones to config select 0 clears those source bits, and a set in the same cycle wins over the clear. `irq` is the OR of source AND mask.
- R9: The `txEvt` bits 0, 1 and 2 latch source bits 0 (transmit frame), 1 (transmit error) and 5 (transmit control).
- R10: After reset the source and mask registers are 0, `irq` is low and no RAM access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable; low rewinds the ring |
| txEvt | input | 3 | Transmit event pulses (frame, error, control) |
| frameDone | input | 1 | One-cycle frame completion event |
| frameLen | input | 16 | Frame length in bytes, frame check sequence included |
| frameErr | input | 9 | Frame flags; bits 7:0 are errors, bit 8 marks a control frame |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 source, 1 mask, 2 transmit count |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for `cfgSel` |
| memReq | output | 1 | Descriptor RAM access request |
| memWe | output | 1 | Descriptor RAM write enable |
| memAddr | output | 12 | Descriptor RAM byte address |
| memWdata | output | 32 | Descriptor RAM write data |
| memRdata | input | 32 | Descriptor RAM read data, one cycle after a read request |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: table base `0x400` and a transmit count cap of 128. With these values the saturation of the count register is reachable, and a random first receive index between 0 and 12 places small rings of two to six descriptors at different spots in the table. The random frames use short rings, so both wrap-around and the full-ring drop case occur often. The default index width is 8 bits, so the natural overflow of the index past 255 is left out of reach.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  localparam int SRC_W     = 7;
  localparam int SRC_TXF   = 0;
  localparam int SRC_TXE   = 1;
  localparam int SRC_RXF   = 2;
  localparam int SRC_RXE   = 3;
  localparam int SRC_BUSY  = 4;
  localparam int SRC_TXC   = 5;
  localparam int SRC_RXC   = 6;

  localparam int FLAG_W    = 9;
  localparam int FLAG_CTL  = 8;
  localparam int LEN_W     = 16;

  localparam int BIT_EMPTY = 15;
  localparam int BIT_IRQ   = 14;
  localparam int BIT_WRAP  = 13;
  localparam int KEEP_LO   = 9;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_TXN  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CHECK = 2'd2
  } ringState_t;

  typedef struct packed {
    logic capture;
    logic readDesc;
    logic writeDesc;
    logic advance;
    logic rewind;
    logic setRxFrame;
    logic setRxErr;
    logic setRxCtl;
    logic setBusy;
  } ringStrobes_t;

endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxEnable,
  input  logic         frameDone,
  input  logic         descEmpty,
  input  logic         descIrq,
  input  logic         capHasErr,
  input  logic         capIsCtl,
  output ringStrobes_t str
);

  ringState_t state, stateNext;

  always_comb begin
    str       = '0;
    stateNext = state;
    if (!rxEnable) begin
      str.rewind = 1'b1;
      stateNext  = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frameDone) begin
            str.capture = 1'b1;
            stateNext   = ST_READ;
          end
        end
        ST_READ: begin
          str.readDesc = 1'b1;
          str.setBusy  = frameDone;
          stateNext    = ST_CHECK;
        end
        ST_CHECK: begin
          if (descEmpty) begin
            str.writeDesc = 1'b1;
            str.advance   = 1'b1;
            if (descIrq) begin
              if (capHasErr)     str.setRxErr   = 1'b1;
              else if (capIsCtl) str.setRxCtl   = 1'b1;
              else               str.setRxFrame = 1'b1;
            end
            str.setBusy = frameDone;
          end else begin
            str.setBusy = 1'b1;
          end
          stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R2: a status write is always preceded by the status read of the same frame
  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    str.writeDesc |-> $past(str.readDesc));

  // R7: with receive disabled, the RAM stays untouched in the following cycle
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !(str.readDesc || str.writeDesc));

endmodule

// File: rtl/rx_ring_dpath.sv
module rx_ring_dpath
  import rx_ring_pkg::*;
#(
  parameter int DESC_BASE = 'h400,
  parameter int IDX_W     = 8,
  parameter int ADDR_W    = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ringStrobes_t       str,
  input  logic [IDX_W-1:0]   ringBase,
  input  logic [LEN_W-1:0]   frameLen,
  input  logic [FLAG_W-1:0]  frameErr,
  input  logic [31:0]        memRdata,
  output logic               descEmpty,
  output logic               descIrq,
  output logic               capHasErr,
  output logic               capIsCtl,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWdata
);

  localparam int OFS_W = IDX_W + 3;

  logic [IDX_W-1:0]  ringPtr;
  logic [LEN_W-1:0]  capLen;
  logic [FLAG_W-1:0] capErr;
  logic              descWrap;
  logic              unusedRdBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capLen <= '0;
      capErr <= '0;
    end else if (str.capture) begin
      capLen <= frameLen;
      capErr <= frameErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ringPtr <= '0;
    else if (str.rewind)  ringPtr <= ringBase;
    else if (str.advance) ringPtr <= descWrap ? ringBase : ringPtr + 1'b1;
  end

  assign descEmpty    = memRdata[BIT_EMPTY];
  assign descIrq      = memRdata[BIT_IRQ];
  assign descWrap     = memRdata[BIT_WRAP];
  assign capHasErr    = |capErr[FLAG_CTL-1:0];
  assign capIsCtl     = capErr[FLAG_CTL];
  assign unusedRdBits = ^{memRdata[31:16], memRdata[KEEP_LO-1:0]};

  assign memReq   = str.readDesc | str.writeDesc;
  assign memWe    = str.writeDesc;
  assign memAddr  = ADDR_W'(DESC_BASE) + ADDR_W'({ringPtr, 3'b000});
  assign memWdata = {capLen, 1'b0, memRdata[BIT_IRQ:KEEP_LO], capErr};

  // R4: without a completed write or a rewind the ring index holds still
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!str.writeDesc && !str.rewind) |=> $stable(ringPtr));

  // R3: leaving a wrap descriptor lands on the first receive descriptor
  assert_wrap_return_R3: assert property (@(posedge clk) disable iff (!rstN)
    (str.advance && descWrap) |=> (ringPtr == $past(ringBase)));

  // R1: descriptor addresses stay inside the table and word aligned
  assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[2:0] == 3'b000 && memAddr >= ADDR_W'(DESC_BASE)));

endmodule

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int TX_CAP = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobes_t      str,
  input  logic [2:0]        txEvt,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic [IDX_W-1:0]  ringBase,
  output logic              irq
);

  logic [SRC_W-1:0] srcReg, maskReg, setVec, clrVec;

  always_comb begin
    setVec            = '0;
    setVec[SRC_TXF]   = txEvt[0];
    setVec[SRC_TXE]   = txEvt[1];
    setVec[SRC_TXC]   = txEvt[2];
    setVec[SRC_RXF]   = str.setRxFrame;
    setVec[SRC_RXE]   = str.setRxErr;
    setVec[SRC_RXC]   = str.setRxCtl;
    setVec[SRC_BUSY]  = str.setBusy;
    clrVec = (cfgWrEn && cfgSel == SEL_SRC) ? cfgWrData[SRC_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      maskReg  <= '0;
      ringBase <= '0;
    end else begin
      srcReg <= (srcReg & ~clrVec) | setVec;
      if (cfgWrEn && cfgSel == SEL_MASK) maskReg <= cfgWrData[SRC_W-1:0];
      if (cfgWrEn && cfgSel == SEL_TXN)
        ringBase <= (cfgWrData > 32'(TX_CAP)) ? IDX_W'(TX_CAP) : cfgWrData[IDX_W-1:0];
    end
  end

  assign irq = |(srcReg & maskReg);

  always_comb begin
    case (cfgSel)
      SEL_SRC:  cfgRdData = 32'(srcReg);
      SEL_MASK: cfgRdData = 32'(maskReg);
      SEL_TXN:  cfgRdData = 32'(ringBase);
      default:  cfgRdData = '0;
    endcase
  end

  // R8: a pure clear leaves none of the written bits set
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == SEL_SRC && setVec == '0) |=> ((srcReg & $past(cfgWrData[SRC_W-1:0])) == '0));

  // R6: a dropped frame is visible in the source register next cycle
  assert_busy_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
    str.setBusy |=> srcReg[SRC_BUSY]);

  // R1: the transmit count never exceeds its cap
  assert_txcount_cap_R1: assert property (@(posedge clk) disable iff (!rstN)
    ringBase <= IDX_W'(TX_CAP));

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rx_ring_pkg::*;
#(
  parameter int DESC_BASE = 'h400,
  parameter int TX_CAP    = 128,
  localparam int IDX_W    = $clog2(TX_CAP) + 1,
  localparam int ADDR_W   = $clog2(DESC_BASE + 8 * (2 ** IDX_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic [2:0]        txEvt,
  input  logic              frameDone,
  input  logic [15:0]       frameLen,
  input  logic [8:0]        frameErr,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              irq
);

  ringStrobes_t     str;
  logic             descEmpty, descIrq, capHasErr, capIsCtl;
  logic [IDX_W-1:0] ringBase;

  rx_ring_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameDone(frameDone),
    .descEmpty(descEmpty), .descIrq(descIrq), .capHasErr(capHasErr),
    .capIsCtl(capIsCtl), .str(str)
  );

  rx_ring_dpath #(.DESC_BASE(DESC_BASE), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .str(str), .ringBase(ringBase),
    .frameLen(frameLen), .frameErr(frameErr), .memRdata(memRdata),
    .descEmpty(descEmpty), .descIrq(descIrq), .capHasErr(capHasErr),
    .capIsCtl(capIsCtl), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  rx_ring_regs #(.IDX_W(IDX_W), .TX_CAP(TX_CAP)) i_regs (
    .clk(clk), .rstN(rstN), .str(str), .txEvt(txEvt), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .ringBase(ringBase), .irq(irq)
  );

endmodule

// File: tb/test_rx_desc_ring.sv
`timescale 1ns/1ps
module test_rx_desc_ring;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0;
  logic [2:0]  txEvt = '0;
  logic        frameDone = 1'b0;
  logic [15:0] frameLen = '0;
  logic [8:0]  frameErr = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        memReq, memWe, irq;
  logic [11:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  logic        tbWrEn = 1'b0;
  logic [9:0]  tbWrIdx = '0;
  logic [31:0] tbWrData = '0;
  logic [31:0] mem [0:1023];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] mirror [0:255];
  int          ringPtr = 0;
  int          ringBaseM = 0;
  logic [6:0]  srcExp = '0;

  always #2 clk = ~clk;

  rx_desc_ring i_rx_desc_ring (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .txEvt(txEvt),
    .frameDone(frameDone), .frameLen(frameLen), .frameErr(frameErr),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (tbWrEn) mem[tbWrIdx] <= tbWrData;
    if (memReq) begin
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else       memRdata <= mem[memAddr[11:2]];
    end
  end

  function automatic int statIdx(input int d);
    return (32'h400 + 8 * d) / 4;
  endfunction

  function automatic logic [31:0] expStatus(input logic [31:0] old, input logic [15:0] len,
                                             input logic [8:0] err);
    return {len, 1'b0, old[14:9], err};
  endfunction

  function automatic logic [6:0] expSrc(input logic [6:0] s, input logic [31:0] old,
                                        input logic [8:0] err);
    if (!old[15]) return s | 7'h10;
    if (!old[14]) return s;
    if (|err[7:0]) return s | 7'h08;
    if (err[8]) return s | 7'h40;
    return s | 7'h04;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    cfgSel = sel;
    #1 v = cfgRdData;
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setDesc(input int d, input logic [31:0] w);
    @(negedge clk);
    tbWrEn = 1'b1; tbWrIdx = 10'(statIdx(d)); tbWrData = w;
    @(negedge clk);
    tbWrEn = 1'b0;
    mirror[d] = w;
  endtask

  task automatic w1c(input logic [6:0] m);
    cfgWrite(2'd0, 32'(m));
    srcExp = srcExp & ~m;
  endtask

  task automatic doFrame(input logic [15:0] len, input logic [8:0] err, input bit dup);
    logic [31:0] old, v;
    int idx;
    idx = ringPtr;
    old = mirror[idx];
    @(negedge clk);
    frameDone = 1'b1; frameLen = len; frameErr = err;
    @(negedge clk);
    if (!dup) frameDone = 1'b0;
    if (rxEnable) begin
      check("R1 status address", 32'(memAddr), 32'h400 + 32'(8 * idx));
      check("R2 read one cycle after frameDone", {30'd0, memReq, memWe}, 32'd2);
    end else begin
      check("R7 no access while disabled", 32'(memReq), 32'd0);
    end
    @(negedge clk);
    frameDone = 1'b0;
    @(negedge clk);
    if (rxEnable) begin
      srcExp = expSrc(srcExp, old, err);
      if (dup) srcExp = srcExp | 7'h10;
      if (old[15]) begin
        mirror[idx] = expStatus(old, len, err);
        ringPtr = old[13] ? ringBaseM : ((ringPtr + 1) % 256);
      end
    end
    check(old[15] ? "R2 written status" : "R4 status left alone",
          mem[statIdx(idx)], mirror[idx]);
    rd(2'd0, v);
    check("R5 source register", v, 32'(srcExp));
  endtask

  task automatic setEnable(input bit en);
    @(negedge clk);
    rxEnable = en;
    if (!en) ringPtr = ringBaseM;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 256; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2'd0, v); check("R10 source after reset", v, 32'd0);
    rd(2'd1, v); check("R10 mask after reset", v, 32'd0);
    rd(2'd2, v); check("R1 transmit count after reset", v, 32'd0);
    check("R10 irq after reset", 32'(irq), 32'd0);
    check("R10 no access after reset", 32'(memReq), 32'd0);

    // R1 saturation
    cfgWrite(2'd2, 32'd200);
    rd(2'd2, v); check("R1 count saturates at 128", v, 32'd128);
    cfgWrite(2'd2, 32'd3);
    rd(2'd2, v); check("R1 count readback", v, 32'd3);
    ringBaseM = 3; ringPtr = 3;
    setDesc(3, 32'h0000_C000);
    setDesc(4, 32'h0000_8000);
    setDesc(5, 32'h0000_E000);
    setEnable(1'b1);

    // R2/R5 good frame; R8 mask behaviour
    doFrame(16'd64, 9'h000, 1'b0);
    check("R8 masked source keeps irq low", 32'(irq), 32'd0);
    cfgWrite(2'd1, 32'h04);
    check("R8 unmasked source raises irq", 32'(irq), 32'd1);
    w1c(7'h04);
    rd(2'd0, v); check("R8 write-one-to-clear", v, 32'(srcExp));
    check("R8 irq drops after clear", 32'(irq), 32'd0);

    // R5 no interrupt request; R5 control frame on wrap descriptor; R3 return
    doFrame(16'd100, 9'h002, 1'b0);
    doFrame(16'd70, 9'h100, 1'b0);
    check("R3 wrapped to first receive index", 32'(ringPtr), 32'd3);

    // R4 full descriptor: dropped, index held (next frame hits the same address)
    doFrame(16'd80, 9'h000, 1'b0);
    doFrame(16'd81, 9'h000, 1'b0);
    w1c(7'h7f);

    // R5 error frame
    setDesc(3, 32'h0000_C000);
    doFrame(16'd90, 9'h008, 1'b0);

    // R6 frame during handling is dropped
    setDesc(4, 32'h0000_C000);
    doFrame(16'd120, 9'h000, 1'b1);
    w1c(7'h7f);

    // R7 disabled receive: ignored, then rewound
    setEnable(1'b0);
    doFrame(16'd99, 9'h000, 1'b0);
    setDesc(3, 32'h0000_C000);
    setEnable(1'b1);
    doFrame(16'd77, 9'h000, 1'b0);
    check("R7 ring restarted at first receive index", 32'(ringPtr), 32'd4);

    // R9 transmit events, set wins over clear
    w1c(7'h7f);
    @(negedge clk); txEvt = 3'b111;
    @(negedge clk); txEvt = 3'b000;
    srcExp = srcExp | 7'h23;
    rd(2'd0, v); check("R9 transmit sources", v, 32'(srcExp));
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 2'd0; cfgWrData = 32'h01; txEvt = 3'b001;
    @(negedge clk);
    cfgWrEn = 1'b0; txEvt = 3'b000;
    rd(2'd0, v); check("R8 set wins over clear", v, 32'(srcExp));
    w1c(7'h7f);

    // random rings
    for (int round = 0; round < 8; round++) begin
      int len;
      setEnable(1'b0);
      ringBaseM = int'($urandom_range(0, 12));
      len = int'($urandom_range(2, 6));
      cfgWrite(2'd2, 32'(ringBaseM));
      ringPtr = ringBaseM;
      for (int d = 0; d < len; d++) begin
        logic [31:0] w;
        w = 32'($urandom) & 32'h0000_41FF;
        if ($urandom_range(0, 9) < 7) w[15] = 1'b1;
        w[13] = (d == len - 1);
        setDesc(ringBaseM + d, w);
      end
      setEnable(1'b1);
      for (int f = 0; f < 25; f++) begin
        logic [8:0] e;
        e = ($urandom_range(0, 1) == 0) ? 9'h000 : 9'($urandom);
        doFrame(16'($urandom_range(64, 1522)), e, $urandom_range(0, 9) == 0);
        if ($urandom_range(0, 1) == 1) begin
          int d;
          d = ringBaseM + int'($urandom_range(0, len - 1));
          setDesc(d, mirror[d] | 32'h8000);
        end
        if ($urandom_range(0, 3) == 0) w1c(7'($urandom));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule